// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours (24-hour form), day of month, weekday, month and a two-digit year. A century bit sits beside the month, and a validity flag beside the seconds. A reference pulse `ref_tick` runs at 32768 Hz and is synchronous to `clk`. A prescaler of `DIV_BITS` bits counts these pulses. Every 2^`DIV_BITS` pulses it advances the seconds, and the carry ripples up through the date in the same cycle. Day-of-month rollover follows the month length, including leap Februaries.

A host-side bus bridge loads and reads the registers through a byte-wide request/response stream. Requests use valid/ready. `req_ready` is high only while no read response is waiting. An accepted read returns its byte on the response channel one cycle later. The response stays valid with stable data until `rsp_ready` takes it, and back-pressure on the response therefore stalls new requests. Writes take effect at the accepting edge and return no response.

A freeze bit in the control byte stops the calendar and clears the prescaler, so software can set the time without a second slipping in between field writes. The validity flag powers up set, meaning "time not trustworthy", and clears once software writes the seconds.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, reads return seconds 0x80 (validity flag set, count 00), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00, control 0x00.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low while `rsp_valid` is high. `rsp_valid` and `rsp_data` hold until an edge with `rsp_ready` high. A write produces no response.
- R3: Address 0x02 holds seconds, 0x03 minutes, 0x04 hours, 0x05 day, 0x06 weekday, 0x07 month and 0x08 year. Writes keep only bits [6:0] of seconds and minutes, bits [5:0] of hours and day, bits [2:0] of weekday and bits [4:0] of month, and all 8 bits of year. Month bit 7 is the century bit. Dropped bits read 0. Address 0x01 and addresses 0x09 to 0x0F read 0x00 and ignore writes.
- R4: Any write to the seconds address clears the validity flag (seconds bit 7), whatever the written bit 7 is.
- R5: While running, the calendar advances by one second on the 2^`DIV_BITS`-th `ref_tick` pulse. A second whose final pulse coincides with an accepted write is dropped.
- R6: Control bit 5 is the freeze bit. While it is set, no field advances and the prescaler is held at zero. After it is cleared, the first advance comes exactly 2^`DIV_BITS` pulses later.
- R7: Control bits 7 and 3 are stored and read back, and they have no effect on counting. All other control bits read 0.
- R8: Seconds and minutes count 00 to 59 and hours 00 to 23, in BCD with digit carry (09 to 10). Each wrap carries into the next field.
- R9: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. The month wraps 12 to 01 and advances the year.
- R10: February ends at 29 when the BCD year is divisible by 4 (including 00), and at 28 otherwise.
- R11: The weekday advances with each day change and counts 0 (Sunday) to 6, then wraps to 0.
- R12: The year wraps from 99 to 00, and that wrap toggles the century bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per 32768 Hz reference period |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read byte |

## Verification
On every cycle the assertions check the stream rules: a stalled response holding its byte, requests blocked while a response waits, and the validity flag falling after a seconds write. They also check that the freeze bit keeps the prescaler at zero and suppresses the second tick, and they check the 59-to-00 seconds wrap and the century toggle at the year wrap. Only the directed scenarios can show the full calendar arithmetic: month lengths, leap-year Februaries, the weekday wrap, the field masks and unused addresses, and the exact pulse count between unfreezing and the first advance.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 7;
  localparam int IDX_W      = $clog2(NUM_FIELDS);
  localparam int FIELD_BASE = 2;
  localparam int CTRL_ADDR  = 0;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_WDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam int CTRL_FREEZE = 5;
  localparam int CTRL_TST_HI = 7;
  localparam int CTRL_TST_LO = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t field_mask(input int idx);
    case (idx)
      F_SEC, F_MIN:   field_mask = 8'h7F;
      F_HOUR, F_DAY:  field_mask = 8'h3F;
      F_WDAY:         field_mask = 8'h07;
      F_MON:          field_mask = 8'h1F;
      default:        field_mask = 8'hFF;
    endcase
  endfunction

  function automatic byte_t field_lo(input int idx);
    field_lo = (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic byte_t bcd_inc(input byte_t v);
    bcd_inc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
  endfunction

  function automatic logic leap_bcd(input byte_t yr);
    if (!yr[4]) leap_bcd = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        leap_bcd = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic byte_t month_last_day(input byte_t mon, input byte_t yr);
    case (mon)
      8'h02:                      month_last_day = leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last_day = 8'h30;
      default:                    month_last_day = 8'h31;
    endcase
  endfunction

  function automatic byte_t field_hi(input int idx, input byte_t mon, input byte_t yr);
    case (idx)
      F_SEC, F_MIN: field_hi = 8'h59;
      F_HOUR:       field_hi = 8'h23;
      F_DAY:        field_hi = month_last_day(mon, yr);
      F_WDAY:       field_hi = 8'h06;
      F_MON:        field_hi = 8'h12;
      default:      field_hi = 8'h99;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                ref_tick,
  output logic [DIV_BITS-1:0] count,
  output logic                tick_out
);
  assign tick_out = ref_tick && !hold && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (hold)     count <= '0;
    else if (ref_tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter byte_t RST_VAL = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_val,
  input  logic  inc,
  input  byte_t lo,
  input  byte_t hi,
  output byte_t val,
  output logic  wrap
);
  assign wrap = inc && (val >= hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= RST_VAL;
    else if (load) val <= load_val;
    else if (inc)  val <= wrap ? lo : bcd_inc(val);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  byte_t                              wr_data,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]  fields,
  output logic [NUM_FIELDS-1:0]              inc,
  output logic                               valid_low,
  output logic                               century
);
  logic [NUM_FIELDS-1:0] wrap;
  logic [NUM_FIELDS-1:0] ld;

  always_comb begin
    inc[F_SEC]  = tick;
    inc[F_MIN]  = wrap[F_SEC];
    inc[F_HOUR] = wrap[F_MIN];
    inc[F_DAY]  = wrap[F_HOUR];
    inc[F_WDAY] = wrap[F_HOUR];
    inc[F_MON]  = wrap[F_DAY];
    inc[F_YEAR] = wrap[F_MON];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    byte_t hi_lim;
    assign ld[i]  = wr_en && (wr_idx == IDX_W'(i));
    assign hi_lim = field_hi(i, fields[F_MON], fields[F_YEAR]);
    rtc_bcd_field #(.RST_VAL(field_lo(i))) u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[i]),
      .load_val (wr_data & field_mask(i)),
      .inc      (inc[i]),
      .lo       (field_lo(i)),
      .hi       (hi_lim),
      .val      (fields[i]),
      .wrap     (wrap[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_low <= 1'b1;
      century   <= 1'b0;
    end else begin
      if (ld[F_SEC]) valid_low <= 1'b0;
      if (ld[F_MON])         century <= wr_data[7];
      else if (wrap[F_YEAR]) century <= ~century;
    end
  end
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  byte_t                             req_wdata,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output byte_t                             rsp_data,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fields,
  input  logic                              valid_low,
  input  logic                              century,
  output logic                              freeze,
  output logic                              wr_any,
  output logic                              fld_wr,
  output logic [IDX_W-1:0]                  fld_idx
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(FIELD_BASE);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(FIELD_BASE + NUM_FIELDS - 1);

  logic  accept, in_fields, is_ctrl;
  logic  tst_hi, tst_lo;
  byte_t rd_byte, ctrl_byte;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign wr_any    = accept && req_write;
  assign is_ctrl   = (req_addr == A_CTRL);
  assign in_fields = (req_addr >= A_LO) && (req_addr <= A_HI);
  assign fld_idx   = IDX_W'(req_addr - A_LO);
  assign fld_wr    = wr_any && in_fields;

  always_comb begin
    ctrl_byte = '0;
    ctrl_byte[CTRL_TST_HI] = tst_hi;
    ctrl_byte[CTRL_FREEZE] = freeze;
    ctrl_byte[CTRL_TST_LO] = tst_lo;
  end

  always_comb begin
    rd_byte = '0;
    if (is_ctrl) begin
      rd_byte = ctrl_byte;
    end else if (in_fields) begin
      rd_byte = fields[fld_idx];
      if (fld_idx == IDX_W'(F_SEC)) rd_byte[7] = valid_low;
      if (fld_idx == IDX_W'(F_MON)) rd_byte[7] = century;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze <= 1'b0;
      tst_hi <= 1'b0;
      tst_lo <= 1'b0;
    end else if (wr_any && is_ctrl) begin
      freeze <= req_wdata[CTRL_FREEZE];
      tst_hi <= req_wdata[CTRL_TST_HI];
      tst_lo <= req_wdata[CTRL_TST_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data
);
  logic                              stop_q;
  logic                              wr_any, fld_wr;
  logic [IDX_W-1:0]                  fld_idx;
  logic [DIV_BITS-1:0]               pre_cnt;
  logic                              pre_tick, sec_tick;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] cal_fields;
  logic [NUM_FIELDS-1:0]             fld_inc;
  logic                              vl_flag, cent_flag;

  assign sec_tick = pre_tick && !wr_any;

  rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (stop_q),
    .ref_tick (ref_tick),
    .count    (pre_cnt),
    .tick_out (pre_tick)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .wr_en     (fld_wr),
    .wr_idx    (fld_idx),
    .wr_data   (req_wdata),
    .fields    (cal_fields),
    .inc       (fld_inc),
    .valid_low (vl_flag),
    .century   (cent_flag)
  );

  rtc_host_port #(.ADDR_W(ADDR_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .fields    (cal_fields),
    .valid_low (vl_flag),
    .century   (cent_flag),
    .freeze    (stop_q),
    .wr_any    (wr_any),
    .fld_wr    (fld_wr),
    .fld_idx   (fld_idx)
  );
endmodule

// File: rtl/rtc_calendar_sva.sv
module rtc_calendar_sva #(
  parameter int DIV_BITS = 15,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [7:0]          rsp_data,
  input logic                stop_q,
  input logic [DIV_BITS-1:0] pre_cnt,
  input logic                sec_tick,
  input logic [6:0]          fld_inc,
  input logic [7:0]          sec_val,
  input logic [7:0]          year_val,
  input logic                vl_flag,
  input logic                cent_flag
);
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_req_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_vl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && (req_addr == ADDR_W'(2)) |=> !vl_flag);

  p_pre_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> pre_cnt == '0);

  p_no_tick_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !sec_tick);

  p_sec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fld_inc[0] && sec_val == 8'h59 |=> sec_val == 8'h00);

  p_century_flip_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fld_inc[6] && year_val == 8'h99 |=> year_val == 8'h00 && cent_flag != $past(cent_flag));
endmodule

bind rtc_calendar_core rtc_calendar_sva #(.DIV_BITS(DIV_BITS), .ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .stop_q    (stop_q),
  .pre_cnt   (pre_cnt),
  .sec_tick  (sec_tick),
  .fld_inc   (fld_inc),
  .sec_val   (cal_fields[0]),
  .year_val  (cal_fields[6]),
  .vl_flag   (vl_flag),
  .cent_flag (cent_flag)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
  localparam int DIVB = 2;
  localparam int PER_SEC = 1 << DIVB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.DIV_BITS(DIVB), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic run_ref(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, w, mo, y);
    wr(4'h0, 8'h20);
    wr(4'h2, s); wr(4'h3, mi); wr(4'h4, h); wr(4'h5, d);
    wr(4'h6, w); wr(4'h7, mo); wr(4'h8, y);
    wr(4'h0, 8'h00);
  endtask

  task automatic expect_date(input string req, input logic [7:0] s, mi, h, d, w, mo, y);
    expect_reg(req, 4'h2, s); expect_reg(req, 4'h3, mi); expect_reg(req, 4'h4, h);
    expect_reg(req, 4'h5, d); expect_reg(req, 4'h6, w); expect_reg(req, 4'h7, mo);
    expect_reg(req, 4'h8, y);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", {7'b0, req_ready}, 8'h01);
    chk("R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);
    expect_reg("R1 ctrl", 4'h0, 8'h00);
    expect_date("R1", 8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
  endtask

  task automatic t_masks;
    wr(4'h0, 8'h20);
    wr(4'h2, 8'hFF); expect_reg("R3/R4 sec mask, flag cleared", 4'h2, 8'h7F);
    wr(4'h3, 8'hFF); expect_reg("R3 min mask", 4'h3, 8'h7F);
    wr(4'h4, 8'hFF); expect_reg("R3 hour mask", 4'h4, 8'h3F);
    wr(4'h5, 8'hFF); expect_reg("R3 day mask", 4'h5, 8'h3F);
    wr(4'h6, 8'hFF); expect_reg("R3 wday mask", 4'h6, 8'h07);
    wr(4'h7, 8'hFF); expect_reg("R3 month mask+century", 4'h7, 8'h9F);
    wr(4'h8, 8'hA5); expect_reg("R3 year full byte", 4'h8, 8'hA5);
    wr(4'h1, 8'hFF); expect_reg("R3 addr1 reads zero", 4'h1, 8'h00);
    wr(4'h9, 8'hFF); expect_reg("R3 addr9 reads zero", 4'h9, 8'h00);
    wr(4'hF, 8'hFF); expect_reg("R3 addrF reads zero", 4'hF, 8'h00);
    expect_reg("R3 year untouched by unused writes", 4'h8, 8'hA5);
    wr(4'h0, 8'hFF); expect_reg("R7 ctrl readback", 4'h0, 8'hA8);
    wr(4'h2, 8'h80); expect_reg("R4 written bit7 ignored", 4'h2, 8'h00);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_handshake;
    logic [7:0] d0;
    wr(4'h0, 8'h20);
    wr(4'h8, 8'h17);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'h8;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 8'h42;
    d0 = rsp_data;
    chk("R2 read data", d0, 8'h17);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 rsp held", {7'b0, rsp_valid}, 8'h01);
      chk("R2 ready low", {7'b0, req_ready}, 8'h00);
      chk("R2 data stable", rsp_data, d0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 rsp released", {7'b0, rsp_valid}, 8'h00);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    chk("R2 write gives no rsp", {7'b0, rsp_valid}, 8'h00);
    expect_reg("R2 stalled write lands", 4'h8, 8'h42);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_prescale;
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h20);
    run_ref(PER_SEC - 1); expect_reg("R5 not yet", 4'h2, 8'h00);
    run_ref(1);           expect_reg("R5 one second", 4'h2, 8'h01);
    run_ref(5 * PER_SEC); expect_reg("R5 five more", 4'h2, 8'h06);
    run_ref(4 * PER_SEC); expect_reg("R8 09 to 10", 4'h2, 8'h10);
  endtask

  task automatic t_freeze;
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h20);
    run_ref(PER_SEC - 2);
    wr(4'h0, 8'h20);
    run_ref(3 * PER_SEC); expect_reg("R6 frozen", 4'h2, 8'h10);
    wr(4'h0, 8'h00);
    run_ref(PER_SEC - 1); expect_reg("R6 prescaler cleared", 4'h2, 8'h10);
    run_ref(1);           expect_reg("R6 resumes", 4'h2, 8'h11);
  endtask

  task automatic t_testbits;
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h20);
    wr(4'h0, 8'h88);
    expect_reg("R7 test bits", 4'h0, 8'h88);
    run_ref(PER_SEC); expect_reg("R7 counts with test bits", 4'h2, 8'h31);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_time_roll;
    set_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h03, 8'h05, 8'h24);
    run_ref(PER_SEC);
    expect_date("R8 midnight", 8'h00, 8'h00, 8'h00, 8'h16, 8'h04, 8'h05, 8'h24);
    set_time(8'h59, 8'h09, 8'h09, 8'h15, 8'h03, 8'h05, 8'h24);
    run_ref(PER_SEC);
    expect_reg("R8 minute 09 to 10", 4'h3, 8'h10);
    expect_reg("R8 hour kept", 4'h4, 8'h09);
  endtask

  task automatic t_month_roll;
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h02, 8'h04, 8'h24);
    run_ref(PER_SEC);
    expect_reg("R9 Apr30 day", 4'h5, 8'h01); expect_reg("R9 Apr30 month", 4'h7, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h02, 8'h05, 8'h24);
    run_ref(PER_SEC);
    expect_reg("R9 May30 to 31", 4'h5, 8'h31);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h02, 8'h12, 8'h24);
    run_ref(PER_SEC);
    expect_date("R9 new year", 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h01, 8'h25);
  endtask

  task automatic t_leap;
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h23);
    run_ref(PER_SEC);
    expect_reg("R10 2023 day", 4'h5, 8'h01); expect_reg("R10 2023 month", 4'h7, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h24);
    run_ref(PER_SEC);
    expect_reg("R10 2024 day29", 4'h5, 8'h29);
    run_ref(86400 * PER_SEC / 86400);
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h24);
    run_ref(PER_SEC);
    expect_reg("R10 2024 Mar1", 4'h7, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h00);
    run_ref(PER_SEC);
    expect_reg("R10 year00 leap", 4'h5, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h12);
    run_ref(PER_SEC);
    expect_reg("R10 year12 leap", 4'h5, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h10);
    run_ref(PER_SEC);
    expect_reg("R10 year10 common", 4'h5, 8'h01);
  endtask

  task automatic t_weekday;
    set_time(8'h59, 8'h59, 8'h23, 8'h10, 8'h06, 8'h03, 8'h24);
    run_ref(PER_SEC);
    expect_reg("R11 Saturday to Sunday", 4'h6, 8'h00);
    set_time(8'h59, 8'h59, 8'h22, 8'h10, 8'h06, 8'h03, 8'h24);
    run_ref(PER_SEC);
    expect_reg("R11 no change within day", 4'h6, 8'h06);
  endtask

  task automatic t_century;
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h12, 8'h99);
    run_ref(PER_SEC);
    expect_reg("R12 year wraps", 4'h8, 8'h00);
    expect_reg("R12 century set", 4'h7, 8'h81);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h92, 8'h99);
    run_ref(PER_SEC);
    expect_reg("R12 century toggles back", 4'h7, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_masks;
    t_handshake;
    t_prescale;
    t_freeze;
    t_testbits;
    t_time_roll;
    t_month_roll;
    t_leap;
    t_weekday;
    t_century;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule